// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block sits between the clock sources of a system clock generator and its output drivers. It gates five groups of clocks: processor clocks, stoppable PCI clocks, one free-running PCI clock, AGP clocks and auxiliary clocks (memory, reference and USB). The gating follows three active-low power-management pins and one enable bit per output. The pins count only while the mode pin is low. A processor-stop request silences the processor group. A PCI-stop request silences the stoppable PCI outputs. The free-running PCI clock and the AGP clocks ignore the PCI-stop request. A power-down request silences every group and raises a power-down indication for the oscillator and PLL control.

Each output has its own two-flop synchroniser in the domain of its source clock. The pin request and the output's enable bit are merged before the synchroniser, so that each output needs only one synchroniser. A flop clocked on the falling edge of the source then updates the gate enable. The enable therefore changes only while the source clock is low. Every high pulse on an output is either whole or absent, both when a clock stops and when it restarts.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, every gated output and pwr_down_o are low.
- R2: When mode_i is 1, the three request pins have no effect. Each output whose enable bit is 1 toggles with its source clock.
- R3: With mode_i=0 and cpu_stop_n_i=0, every bit of cpu_clk_o stays low. The other groups are unaffected.
- R4: With mode_i=0 and pci_stop_n_i=0, every bit of pci_clk_o stays low. pcif_clk_o and agp_clk_o keep toggling.
- R5: With mode_i=0 and pwr_dwn_n_i=0, every gated output is low and pwr_down_o is 1. When the pin is released, the outputs restart and pwr_down_o returns to 0.
- R6: Bit i of each enable port controls bit i of the matching output. A value of 0 holds that output low whatever the pins are. A value of 1 lets the output run unless a pin request covers its group.
- R7: A gated output is high only during the high phase of its source. Each high pulse lasts the whole high phase.
- R8: With SYNC_STAGES=2, a request applied during a low phase leaves the high phases after the next two rising edges of the source unchanged. The new state applies from the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_clk_i | input | 1 | Processor clock source |
| pci_clk_i | input | 1 | PCI clock source (stoppable and free-running outputs) |
| agp_clk_i | input | 1 | AGP clock source |
| aux_clk_i | input | 1 | Auxiliary clock source |
| mode_i | input | 1 | 0 enables the power-management pins |
| cpu_stop_n_i | input | 1 | Processor clock stop request, active low |
| pci_stop_n_i | input | 1 | PCI clock stop request, active low |
| pwr_dwn_n_i | input | 1 | Power-down request, active low |
| cpu_en_i | input | N_CPU | Per-output enable, processor group |
| pci_en_i | input | N_PCI | Per-output enable, stoppable PCI group |
| pcif_en_i | input | 1 | Enable of the free-running PCI output |
| agp_en_i | input | N_AGP | Per-output enable, AGP group |
| aux_en_i | input | N_AUX | Per-output enable, auxiliary group |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated stoppable PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| agp_clk_o | output | N_AGP | Gated AGP clocks |
| aux_clk_o | output | N_AUX | Gated auxiliary clocks |
| pwr_down_o | output | 1 | Power-down indication, aux domain |

## Verification
A gate enable updated on the wrong clock edge appears at the port at once. The output then shows a high level while its source is low, or a high phase cut short, at the first edge where the enable moves. A wrongly decoded group, or a stuck synchroniser stage, leaves an output at the wrong level in its high phase. This shows within SYNC_STAGES+1 cycles of its source after a pin or enable change. A wrong power-down flop shows on pwr_down_o in the same aux cycle in which the aux outputs go silent.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

   typedef enum logic [2:0] {
      GRP_CPU,
      GRP_PCI,
      GRP_PCIF,
      GRP_AGP,
      GRP_AUX
   } grp_e;

   typedef struct packed {
      logic cpu;
      logic pci;
      logic pwr;
   } pm_req_t;

   // Which decoded requests silence a given group.
   function automatic logic group_stopped(grp_e g, pm_req_t r);
      case (g)
         GRP_CPU: return r.pwr | r.cpu;
         GRP_PCI: return r.pwr | r.pci;
         default: return r.pwr;
      endcase
   endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cs_gate_cell.sv
module cs_gate_cell #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stop_i,
   output logic clk_o
);
   logic stop_s;
   logic en_q;

   cs_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (stop_i),
      .q_o   (stop_s)
   );

   // Enable moves only on the falling edge, so the source is low when it does.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= ~stop_s;
   end

   assign clk_o = clk_i & en_q;
endmodule

// File: rtl/cs_gate_bank.sv
module cs_gate_bank
   import clk_stop_pkg::*;
#(
   parameter grp_e GROUP  = GRP_CPU,
   parameter int   WIDTH  = 1,
   parameter int   STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  pm_req_t          req_i,
   input  logic [WIDTH-1:0] en_i,
   output logic [WIDTH-1:0] clk_o
);
   logic grp_stop;
   assign grp_stop = group_stopped(GROUP, req_i);

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      cs_gate_cell #(.STAGES(STAGES)) u_cell (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .stop_i(grp_stop | ~en_i[i]),
         .clk_o (clk_o[i])
      );
   end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
   import clk_stop_pkg::*;
#(
   parameter int N_CPU       = 4,
   parameter int N_PCI       = 4,
   parameter int N_AGP       = 2,
   parameter int N_AUX       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             rst_ni,
   input  logic             cpu_clk_i,
   input  logic             pci_clk_i,
   input  logic             agp_clk_i,
   input  logic             aux_clk_i,
   input  logic             mode_i,
   input  logic             cpu_stop_n_i,
   input  logic             pci_stop_n_i,
   input  logic             pwr_dwn_n_i,
   input  logic [N_CPU-1:0] cpu_en_i,
   input  logic [N_PCI-1:0] pci_en_i,
   input  logic             pcif_en_i,
   input  logic [N_AGP-1:0] agp_en_i,
   input  logic [N_AUX-1:0] aux_en_i,
   output logic [N_CPU-1:0] cpu_clk_o,
   output logic [N_PCI-1:0] pci_clk_o,
   output logic             pcif_clk_o,
   output logic [N_AGP-1:0] agp_clk_o,
   output logic [N_AUX-1:0] aux_clk_o,
   output logic             pwr_down_o
);
   localparam int MIN_SYNC = 2;

   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("clk_stop_ctrl: SYNC_STAGES below two");
   end
   if (N_CPU < 1 || N_PCI < 1 || N_AGP < 1 || N_AUX < 1) begin : g_bad_width
      $error("clk_stop_ctrl: every group needs at least one output");
   end

   // Pin decode: requests count only while mode_i is low.
   pm_req_t req;
   assign req.cpu = ~mode_i & ~cpu_stop_n_i;
   assign req.pci = ~mode_i & ~pci_stop_n_i;
   assign req.pwr = ~mode_i & ~pwr_dwn_n_i;

   cs_gate_bank #(.GROUP(GRP_CPU), .WIDTH(N_CPU), .STAGES(SYNC_STAGES)) u_cpu (
      .clk_i(cpu_clk_i), .rst_ni(rst_ni), .req_i(req), .en_i(cpu_en_i), .clk_o(cpu_clk_o)
   );
   cs_gate_bank #(.GROUP(GRP_PCI), .WIDTH(N_PCI), .STAGES(SYNC_STAGES)) u_pci (
      .clk_i(pci_clk_i), .rst_ni(rst_ni), .req_i(req), .en_i(pci_en_i), .clk_o(pci_clk_o)
   );
   cs_gate_bank #(.GROUP(GRP_PCIF), .WIDTH(1), .STAGES(SYNC_STAGES)) u_pcif (
      .clk_i(pci_clk_i), .rst_ni(rst_ni), .req_i(req), .en_i(pcif_en_i), .clk_o(pcif_clk_o)
   );
   cs_gate_bank #(.GROUP(GRP_AGP), .WIDTH(N_AGP), .STAGES(SYNC_STAGES)) u_agp (
      .clk_i(agp_clk_i), .rst_ni(rst_ni), .req_i(req), .en_i(agp_en_i), .clk_o(agp_clk_o)
   );
   cs_gate_bank #(.GROUP(GRP_AUX), .WIDTH(N_AUX), .STAGES(SYNC_STAGES)) u_aux (
      .clk_i(aux_clk_i), .rst_ni(rst_ni), .req_i(req), .en_i(aux_en_i), .clk_o(aux_clk_o)
   );

   // Power-down indication, timed like the aux gates.
   logic pd_s;
   logic pd_q;

   cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
      .clk_i (aux_clk_i),
      .rst_ni(rst_ni),
      .d_i   (req.pwr),
      .q_o   (pd_s)
   );

   always_ff @(negedge aux_clk_i or negedge rst_ni) begin
      if (!rst_ni) pd_q <= 1'b0;
      else         pd_q <= pd_s;
   end

   assign pwr_down_o = pd_q;
endmodule

// File: rtl/clk_stop_chk.sv
module clk_grp_chk #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [W-1:0] want_i,
   input logic [W-1:0] got_i
);
   localparam int LIM = STAGES + 1;
   localparam int CW  = $clog2(LIM + 1);

   logic [W-1:0]  want_q;
   logic [CW-1:0] calm_q;

   // Counts falling edges over which the expected vector has not moved.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         want_q <= '0;
         calm_q <= '0;
      end else begin
         want_q <= want_i;
         if (want_i != want_q)       calm_q <= '0;
         else if (calm_q < CW'(LIM)) calm_q <= calm_q + 1'b1;
      end
   end

   // Covers R2 R3 R4 R5 R6: settled high-phase level matches the decode.
   a_r6_steady_match: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (calm_q == CW'(LIM) && want_i == want_q) |-> got_i == want_i);

   for (genvar i = 0; i < W; i++) begin : g_bit
      always @(posedge got_i[i]) begin
         if (rst_ni) a_r7_rise_in_high: assert (clk_i);
      end
      always @(negedge got_i[i]) begin
         if (rst_ni) a_r7_fall_in_low: assert (!clk_i);
      end
   end
endmodule

module clk_stop_chk #(
   parameter int N_CPU       = 4,
   parameter int N_PCI       = 4,
   parameter int N_AGP       = 2,
   parameter int N_AUX       = 3,
   parameter int SYNC_STAGES = 2
) (
   input logic             rst_ni,
   input logic             cpu_clk_i,
   input logic             pci_clk_i,
   input logic             agp_clk_i,
   input logic             aux_clk_i,
   input logic             mode_i,
   input logic             cpu_stop_n_i,
   input logic             pci_stop_n_i,
   input logic             pwr_dwn_n_i,
   input logic [N_CPU-1:0] cpu_en_i,
   input logic [N_PCI-1:0] pci_en_i,
   input logic             pcif_en_i,
   input logic [N_AGP-1:0] agp_en_i,
   input logic [N_AUX-1:0] aux_en_i,
   input logic [N_CPU-1:0] cpu_clk_o,
   input logic [N_PCI-1:0] pci_clk_o,
   input logic             pcif_clk_o,
   input logic [N_AGP-1:0] agp_clk_o,
   input logic [N_AUX-1:0] aux_clk_o,
   input logic             pwr_down_o
);
   logic pm_on, all_off, cpu_off, pci_off;
   assign pm_on   = !mode_i;
   assign all_off = pm_on && !pwr_dwn_n_i;
   assign cpu_off = all_off || (pm_on && !cpu_stop_n_i);
   assign pci_off = all_off || (pm_on && !pci_stop_n_i);

   logic [N_CPU-1:0] want_cpu;
   logic [N_PCI-1:0] want_pci;
   logic             want_pcif;
   logic [N_AGP-1:0] want_agp;
   logic [N_AUX-1:0] want_aux;
   assign want_cpu  = cpu_off ? '0 : cpu_en_i;
   assign want_pci  = pci_off ? '0 : pci_en_i;
   assign want_pcif = all_off ? 1'b0 : pcif_en_i;
   assign want_agp  = all_off ? '0 : agp_en_i;
   assign want_aux  = all_off ? '0 : aux_en_i;

   clk_grp_chk #(.W(N_CPU), .STAGES(SYNC_STAGES)) u_c_cpu (
      .clk_i(cpu_clk_i), .rst_ni(rst_ni), .want_i(want_cpu), .got_i(cpu_clk_o));
   clk_grp_chk #(.W(N_PCI), .STAGES(SYNC_STAGES)) u_c_pci (
      .clk_i(pci_clk_i), .rst_ni(rst_ni), .want_i(want_pci), .got_i(pci_clk_o));
   clk_grp_chk #(.W(1), .STAGES(SYNC_STAGES)) u_c_pcif (
      .clk_i(pci_clk_i), .rst_ni(rst_ni), .want_i(want_pcif), .got_i(pcif_clk_o));
   clk_grp_chk #(.W(N_AGP), .STAGES(SYNC_STAGES)) u_c_agp (
      .clk_i(agp_clk_i), .rst_ni(rst_ni), .want_i(want_agp), .got_i(agp_clk_o));
   clk_grp_chk #(.W(N_AUX), .STAGES(SYNC_STAGES)) u_c_aux (
      .clk_i(aux_clk_i), .rst_ni(rst_ni), .want_i(want_aux), .got_i(aux_clk_o));

   // R5: while power-down is flagged, no aux high phase reaches the pins.
   a_r5_pd_quiet: assert property (@(negedge aux_clk_i) disable iff (!rst_ni)
      pwr_down_o |-> aux_clk_o == '0);

   // R1: the indication stays low throughout reset.
   always @(negedge aux_clk_i) begin
      if (!rst_ni) a_r1_pd_reset_low: assert (!pwr_down_o);
   end
endmodule

bind clk_stop_ctrl clk_stop_chk #(
   .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .N_AUX(N_AUX), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
   localparam int NC = 4, NP = 4, NA = 2, NX = 3;

   logic cpu_clk = 1'b0, pci_clk = 1'b0, agp_clk = 1'b0, aux_clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b1, cpu_n = 1'b1, pci_n = 1'b1, pwr_n = 1'b1;
   logic [15:0] pat = 16'hFFFF;

   logic [NC-1:0] cpu_o;
   logic [NP-1:0] pci_o;
   logic          pcif_o;
   logic [NA-1:0] agp_o;
   logic [NX-1:0] aux_o;
   logic          pd_o;

   int n_chk = 0, n_fail = 0;

   always #4 cpu_clk = ~cpu_clk;
   initial begin #1; forever #8 pci_clk = ~pci_clk; end
   initial begin #2; forever #6 agp_clk = ~agp_clk; end
   always #10 aux_clk = ~aux_clk;

   clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_AGP(NA), .N_AUX(NX), .SYNC_STAGES(2)) dut (
      .rst_ni(rst_n), .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .agp_clk_i(agp_clk),
      .aux_clk_i(aux_clk), .mode_i(mode), .cpu_stop_n_i(cpu_n), .pci_stop_n_i(pci_n),
      .pwr_dwn_n_i(pwr_n), .cpu_en_i(pat[NC-1:0]), .pci_en_i(pat[NP-1:0]),
      .pcif_en_i(pat[2]), .agp_en_i(pat[NA-1:0]), .aux_en_i(pat[NX-1:0]),
      .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pcif_clk_o(pcif_o), .agp_clk_o(agp_o),
      .aux_clk_o(aux_o), .pwr_down_o(pd_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h (mode=%b cpu=%b pci=%b pwr=%b pat=%h)",
                  tag, what, act, exp, mode, cpu_n, pci_n, pwr_n, pat);
      end
   endtask

   function automatic logic [15:0] mk_pat(int k);
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = (k == 0) ? 1'b1 : (((i + k) % 3) != 0);
      return v;
   endfunction

   function automatic logic [15:0] width_mask(int w);
      return 16'((32'd1 << w) - 1);
   endfunction

   // Expected running vector of group g from the requirements.
   function automatic logic [15:0] exp_vec(int g);
      logic pm, off_all, off;
      logic [15:0] m;
      pm      = !mode;
      off_all = pm && !pwr_n;
      case (g)
         0: begin off = off_all || (pm && !cpu_n); m = pat & width_mask(NC); end
         1: begin off = off_all || (pm && !pci_n); m = pat & width_mask(NP); end
         2: begin off = off_all;                   m = {15'd0, pat[2]};      end
         3: begin off = off_all;                   m = pat & width_mask(NA); end
         default: begin off = off_all;             m = pat & width_mask(NX); end
      endcase
      return off ? 16'd0 : m;
   endfunction

   function automatic string tag_for(int g);
      if (mode)                          return "R2";
      if (!pwr_n)                        return "R5";
      if (g == 0 && !cpu_n)              return "R3";
      if (g >= 1 && g <= 3 && !pci_n)    return "R4";
      return "R6";
   endfunction

   task automatic grp_check(input int g);
      logic [15:0] a, b, c, e;
      a = '0; b = '0; c = '0;
      e = exp_vec(g);
      case (g)
         0: begin @(posedge cpu_clk); #1 a[NC-1:0] = cpu_o; #2 b[NC-1:0] = cpu_o;
                  @(negedge cpu_clk); #1 c[NC-1:0] = cpu_o; end
         1: begin @(posedge pci_clk); #1 a[NP-1:0] = pci_o; #6 b[NP-1:0] = pci_o;
                  @(negedge pci_clk); #1 c[NP-1:0] = pci_o; end
         2: begin @(posedge pci_clk); #1 a[0] = pcif_o; #6 b[0] = pcif_o;
                  @(negedge pci_clk); #1 c[0] = pcif_o; end
         3: begin @(posedge agp_clk); #1 a[NA-1:0] = agp_o; #4 b[NA-1:0] = agp_o;
                  @(negedge agp_clk); #1 c[NA-1:0] = agp_o; end
         default: begin @(posedge aux_clk); #1 a[NX-1:0] = aux_o; #8 b[NX-1:0] = aux_o;
                  @(negedge aux_clk); #1 c[NX-1:0] = aux_o; end
      endcase
      check(tag_for(g), $sformatf("grp%0d early high", g), a, e);
      check("R7", $sformatf("grp%0d late high", g), b, e);
      check("R7", $sformatf("grp%0d low phase", g), c, 16'd0);
   endtask

   task automatic apply(input logic md, input logic c, input logic p, input logic w, input int k);
      @(negedge cpu_clk); #1;
      mode = md; cpu_n = c; pci_n = p; pwr_n = w; pat = mk_pat(k);
   endtask

   initial begin
      // R1: everything quiet while in reset, across several phases.
      repeat (12) begin
         #3;
         check("R1", "outputs in reset", {cpu_o, pci_o, pcif_o, agp_o, aux_o}, 16'd0);
         check("R1", "pd in reset", {15'd0, pd_o}, 16'd0);
      end
      @(negedge cpu_clk); #1 rst_n = 1'b1;

      for (int md = 0; md < 2; md++) begin
         for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 3; k++) begin
               apply(md[0], p[2], p[1], p[0], k);
               repeat (25) @(posedge cpu_clk);
               for (int g = 0; g < 5; g++) grp_check(g);
               @(negedge aux_clk); #1;
               check(mode ? "R2" : "R5", "pd level", {15'd0, pd_o},
                     {15'd0, !mode && !pwr_n});
            end
         end
      end

      // R8: processor stop timing, counted in source rising edges.
      apply(1'b0, 1'b1, 1'b1, 1'b1, 0);
      repeat (10) @(posedge cpu_clk);
      @(negedge cpu_clk); #1 cpu_n = 1'b0;
      @(posedge cpu_clk); #2 check("R8", "stop edge1", {12'd0, cpu_o}, width_mask(NC));
      @(posedge cpu_clk); #2 check("R8", "stop edge2", {12'd0, cpu_o}, width_mask(NC));
      @(posedge cpu_clk); #2 check("R8", "stop edge3", {12'd0, cpu_o}, 16'd0);
      @(negedge cpu_clk); #1 cpu_n = 1'b1;
      @(posedge cpu_clk); #2 check("R8", "start edge1", {12'd0, cpu_o}, 16'd0);
      @(posedge cpu_clk); #2 check("R8", "start edge2", {12'd0, cpu_o}, 16'd0);
      @(posedge cpu_clk); #2 check("R8", "start edge3", {12'd0, cpu_o}, width_mask(NC));

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #150000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule